// File: doc/BRIEF.md
# Incremental Encoder Quadrature Counter

This block turns the two phase-shifted square waves of a linear incremental encoder into a signed position count. Both channels are first brought into the system clock domain through a synchroniser chain. A sampling stage then compares each channel with its value on the previous cycle. Every transition on either channel produces a one-clock count pulse together with a direction bit. Because every edge is counted, each encoder pitch yields four counts.

The position register accumulates the pulses in two's complement and can be read at any time. A synchronous clear zeroes it. If both channels change between two samples, the motion cannot be resolved: no count is made and a sticky error flag is raised. Only the clear removes that flag. The system clock must run at more than eight times the encoder output frequency, so that successive edges are always at least one sample apart.

Top module: `quad_pos_counter`

## Requirements
- R1: While rst_ni is low, and after it is released, pos_o is 0, cnt_o is 0, dir_o is 0 and err_o is 0.
- R2: A change on exactly one channel gives a cnt_o pulse exactly one clock wide. It appears after the third rising clock edge that follows the input change: two synchroniser stages and one output register.
- R3: Forward motion, with (a_i,b_i) stepping 00→01→11→10→00, adds 1 to pos_o per step, and dir_o is 1 with each pulse.
- R4: Reverse motion, with (a_i,b_i) stepping 00→10→11→01→00, subtracts 1 from pos_o per step, and dir_o is 0 with each pulse.
- R5: pos_o updates on the same clock edge on which cnt_o rises. A direction reversal in the middle of a pitch is counted correctly. Each full pitch therefore moves pos_o by exactly four.
- R6: If both channels change between two samples, no pulse is issued and pos_o is unchanged. err_o goes to 1 and stays at 1 until a clear, while later valid edges are still counted.
- R7: clr_i, sampled on a rising edge, sets pos_o to 0 and err_o to 0. It suppresses any count that falls on the same edge.
- R8: pos_o is POS_W-bit two's complement and wraps modulo 2^POS_W, in both directions.
- R9: While neither channel changes, cnt_o stays 0 and pos_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of position and error |
| a_i | input | 1 | Encoder channel A, asynchronous |
| b_i | input | 1 | Encoder channel B, asynchronous |
| cnt_o | output | 1 | One-clock count pulse |
| dir_o | output | 1 | Direction of the last count, 1 = up |
| err_o | output | 1 | Sticky flag for an unresolvable double change |
| pos_o | output | POS_W | Signed position count |

## Verification
The bench builds the block with POS_W = 8 and keeps two synchroniser stages. The 8-bit width brings the negative wrap of R8 within a few hundred cycles: 32 reverse pitches reach -128, and one more pitch wraps the value to +124. Holding the synchroniser depth at two fixes the three-edge latency, and the bench samples each pulse and position exactly at that point.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef struct packed {
    logic a;
    logic b;
  } ab_t;
  localparam int unsigned AB_W = $bits(ab_t);
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qd_edge.sv
module qd_edge
  import qd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ab_t  now_i,
  output logic step_o,
  output logic up_o,
  output logic both_o
);
  ab_t prev_q;
  logic chg_a, chg_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= now_i;
  end

  assign chg_a  = now_i.a ^ prev_q.a;
  assign chg_b  = now_i.b ^ prev_q.b;
  assign step_o = chg_a ^ chg_b;
  assign both_o = chg_a & chg_b;
  // previous A against present B resolves direction without a state table
  assign up_o   = prev_q.a ^ now_i.b;
endmodule

// File: rtl/qd_accum.sv
module qd_accum #(
  parameter int unsigned POS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             both_i,
  output logic             cnt_o,
  output logic             dir_o,
  output logic             err_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= 1'b0;
      dir_o <= 1'b0;
      err_o <= 1'b0;
      pos_o <= '0;
    end else if (clr_i) begin
      cnt_o <= 1'b0;
      err_o <= 1'b0;
      pos_o <= '0;
    end else begin
      cnt_o <= step_i;
      if (both_i) err_o <= 1'b1;
      if (step_i) begin
        dir_o <= up_i;
        pos_o <= up_i ? pos_o + ONE : pos_o - ONE;
      end
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qd_pkg::*;
#(
  parameter int unsigned POS_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             a_i,
  input  logic             b_i,
  output logic             cnt_o,
  output logic             dir_o,
  output logic             err_o,
  output logic [POS_W-1:0] pos_o
);
  ab_t raw_ab, sync_ab;
  logic step, up, both;

  assign raw_ab = '{a: a_i, b: b_i};

  qd_sync #(.STAGES(SYNC_STAGES), .WIDTH(AB_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_ab),
    .q_o   (sync_ab)
  );

  qd_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .now_i (sync_ab),
    .step_o(step),
    .up_o  (up),
    .both_o(both)
  );

  qd_accum #(.POS_W(POS_W)) u_accum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .step_i(step),
    .up_i  (up),
    .both_i(both),
    .cnt_o (cnt_o),
    .dir_o (dir_o),
    .err_o (err_o),
    .pos_o (pos_o)
  );
endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int unsigned POS_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             cnt_o,
  input logic             dir_o,
  input logic             err_o,
  input logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  a_r3_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o && dir_o) |-> pos_o == $past(pos_o) + ONE);

  a_r4_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o && !dir_o) |-> pos_o == $past(pos_o) - ONE);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_o && !$past(clr_i)) |-> $stable(pos_o));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);

  a_r6_no_count_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !cnt_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pos_o == '0 && !err_o && !cnt_o));
endmodule

bind quad_pos_counter quad_pos_counter_chk #(.POS_W(POS_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .clr_i (clr_i),
  .cnt_o (cnt_o),
  .dir_o (dir_o),
  .err_o (err_o),
  .pos_o (pos_o)
);

// File: tb/quad_pos_counter_bench.sv
`timescale 1ns/1ps
module quad_pos_counter_bench;
  localparam int unsigned POS_W = 8;
  localparam int NVEC = 11;
  // {a, b, exp_cnt, exp_dir, exp_pos}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 8'd1},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'd2},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'd3},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd4},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'd4},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd3},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd2},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'd1},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd0},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'd1},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, a = 1'b0, b = 1'b0;
  logic cnt, dir, err;
  logic [POS_W-1:0] pos;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  quad_pos_counter #(.POS_W(POS_W)) u_quad_pos_counter (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .a_i(a), .b_i(b),
    .cnt_o(cnt), .dir_o(dir), .err_o(err), .pos_o(pos)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the third edge
  task automatic drive(logic na, logic nb);
    @(negedge clk);
    a = na; b = nb;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R1 R2 R3 R4 R5 R6 R7 R8 R9 got=hang exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 pos in reset", 32'(pos), 0);
    check("R1 cnt/err/dir in reset", {cnt, err, dir}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pos after reset", 32'(pos), 0);
    check("R1 cnt/err/dir after reset", {cnt, err, dir}, 0);

    // R3 R4 R5 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][11], VEC[i][10]);
      check($sformatf("R2/R3/R4/R9 vec %0d cnt", i), 32'(cnt), 32'(VEC[i][9]));
      check($sformatf("R3/R4 vec %0d dir", i), 32'(dir), 32'(VEC[i][8]));
      check($sformatf("R5 vec %0d pos", i), 32'(pos), 32'(VEC[i][7:0]));
      @(posedge clk); #1;
      check($sformatf("R2 vec %0d pulse width", i), 32'(cnt), 0);
    end

    // R2 latency: nothing after only two edges
    @(negedge clk); a = 1'b1; b = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R2 no pulse before third edge", 32'(cnt), 0);
    @(posedge clk); #1;
    check("R2 pulse at third edge", 32'(cnt), 1);
    check("R4 step down to -1", 32'(pos), 32'hFF);
    drive(1'b0, 1'b0);
    check("R3 back to 0", 32'(pos), 0);

    // R6 double change
    drive(1'b1, 1'b1);
    check("R6 no pulse on double change", 32'(cnt), 0);
    check("R6 pos unchanged", 32'(pos), 0);
    check("R6 err set", 32'(err), 1);
    drive(1'b1, 1'b0);
    check("R6 later edge still counted", 32'(pos), 1);
    repeat (4) @(posedge clk); #1;
    check("R6 err sticky", 32'(err), 1);

    // R7 clear
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check("R7 clear pos", 32'(pos), 0);
    check("R7 clear err", 32'(err), 0);

    // R7 clear beats a coincident count (10 -> 00 is up)
    @(negedge clk); a = 1'b0; b = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) clr = 1'b1;
    @(posedge clk); #1;
    check("R7 clear suppresses pulse", 32'(cnt), 0);
    check("R7 clear suppresses count", 32'(pos), 0);
    @(negedge clk) clr = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R9 stable after clear", 32'(pos), 0);

    // R8 negative wrap
    for (int p = 0; p < 32; p++) begin
      drive(1'b1, 1'b0); drive(1'b1, 1'b1); drive(1'b0, 1'b1); drive(1'b0, 1'b0);
    end
    check("R8 reach -128", 32'(pos), 32'h80);
    drive(1'b1, 1'b0);
    check("R8 wrap to +127", 32'(pos), 32'h7F);
    drive(1'b1, 1'b1); drive(1'b0, 1'b1); drive(1'b0, 1'b0);
    check("R8 R5 one more pitch", 32'(pos), 32'd124);
    // R8 positive wrap back
    drive(1'b0, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
    check("R8 forward pitch to +128 wraps", 32'(pos), 32'h80);
    check("R3 dir up", 32'(dir), 1);

    finish_run();
  end
endmodule